// File: doc/BRIEF.md
# Variable-Length Instruction Extraction Muxer

This block takes one fetch buffer of 32 bytes together with the execution mode in force at its first byte, and splits it into up to four instruction slots of 64 bits each in one pass of combinational logic. Instructions are 2 bytes long in compressed mode and 4 or 8 bytes long in standard mode. Each slot starts where the previous slot ended, so the start offsets form a chain of length decodes. Each slot's byte selector is built only for the offsets that the chain can actually reach.

In compressed mode the buffer carries a mode-switch byte at byte 0, so compressed instructions sit on odd byte positions. The block steps over that leading byte without placing it in a slot. A later switch byte, seen where an instruction would begin, toggles the mode for what follows and is likewise consumed without a slot. As a result, standard instructions always start at even offsets and compressed ones at odd offsets. The fetch stage uses the reported byte count to advance its buffer. An optional output register stage is available.

Top module: `isx_extract`

## Requirements
- R1: In standard initial mode, slot 0 starts at byte 0 unless byte 0 holds the switch byte 8'hFB, in which case it starts at byte 1 in compressed mode.
- R2: In compressed initial mode, byte 0 is always skipped whatever its value and does not toggle the mode; slot 0 starts at byte 1 with the compressed flag set.
- R3: Length is 2 bytes in compressed mode. In standard mode it is 8 bytes when bits [7:2] of the instruction's first byte equal 6'h05, and 4 bytes otherwise.
- R4: The cursor for slot k+1 is the end offset (start plus length) of slot k.
- R5: At most one switch byte 8'hFB at a slot's cursor is consumed before that slot and toggles the mode. A second switch byte directly after it is decoded as the first byte of an instruction. In compressed initial mode, slot 0 takes the leading skip of R2 instead and checks for no switch byte.
- R6: Slot k occupies bits [64k+63:64k] of the word output. The byte at the start offset lands in bits [7:0], the following bytes land in ascending byte lanes, and bytes beyond the instruction length are zero.
- R7: A slot is valid only if the previous slot is valid, its cursor lies inside the buffer, and its start plus its length does not exceed the buffer size. An invalid slot outputs an all-zero word and a zero compressed flag.
- R8: The used-byte count equals the end offset of the last valid slot, or 0 when no slot is valid. Valid flags always form a contiguous run from slot 0.
- R9: A valid slot's compressed flag gives the mode it was decoded in, and equals bit 0 of its start offset.
- R10: Slot k's selector accepts only starts in the set reachable from the length and switch rules. With no switch bytes in the buffer, the last slot can start no later than byte 24.
- R11: With the output register enabled, every output equals the combinational result one clock later, and all outputs are zero while reset is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset for the output register |
| fetch_buf | input | 256 | Fetch buffer; byte i in bits [8i+7:8i] |
| start_cmp | input | 1 | Execution mode at byte 0 (1 = compressed) |
| slot_word | output | 256 | Four zero-extended 64-bit slot words |
| slot_vld | output | 4 | Valid flag per slot |
| slot_cmp | output | 4 | Compressed-mode flag per slot |
| used_bytes | output | 6 | Bytes consumed by the valid slots |

## Verification
Uniform short and uniform long standard buffers show that the start chain accumulates 4- and 8-byte lengths, and the all-long case places the last slot at byte 24 and consumes exactly 32 bytes. A compressed buffer with an arbitrary leading byte shows that the leading byte is skipped without toggling. Buffers with isolated and doubled switch bytes separate a toggle that is consumed from a second switch byte that must be decoded as an instruction. A 16-byte variant fed with long instructions drives slots past the buffer end, which exercises invalidation and the used-byte count. Random buffers drawn from short, long, switch and arbitrary bytes are checked in both modes against a sequential model, on the combinational outputs and again on the registered ones.

// File: rtl/isx_pkg.sv
package isx_pkg;

  localparam logic [7:0] SWITCH_BYTE = 8'hFB;
  localparam logic [5:0] LONG_MAJOR  = 6'h05;
  localparam int         MAX_LEN     = 8;
  localparam int         MASK_W      = 128;

  // Instruction length in bytes from the mode and the first byte.
  function automatic logic [3:0] insn_len(input logic cmp, input logic [7:0] first);
    if (cmp)                          return 4'd2;
    else if (first[7:2] == LONG_MAJOR) return 4'd8;
    else                              return 4'd4;
  endfunction

  function automatic logic is_switch(input logic [7:0] b);
    return b == SWITCH_BYTE;
  endfunction

  // Start offsets slot 'slot' can reach. Odd starts are compressed (2 bytes),
  // even starts are standard (4 or 8 bytes); a switch byte adds one.
  function automatic logic [MASK_W-1:0] reach_mask(input int slot);
    logic [MASK_W-1:0] cur, st, nxt;
    cur = '0;
    cur[0] = 1'b1;
    st = '0;
    for (int j = 0; j <= slot; j++) begin
      st  = cur | (cur << 1);
      nxt = '0;
      for (int p = 0; p < MASK_W; p++) begin
        if (st[p]) begin
          if (p % 2 == 1) begin
            if (p + 2 < MASK_W) nxt[p+2] = 1'b1;
          end else begin
            if (p + 4 < MASK_W) nxt[p+4] = 1'b1;
            if (p + 8 < MASK_W) nxt[p+8] = 1'b1;
          end
        end
      end
      cur = nxt;
    end
    return st;
  endfunction

endpackage

// File: rtl/isx_step.sv
module isx_step
  import isx_pkg::*;
#(
  parameter int BUF_BYTES = 32,
  parameter int OFF_W     = 7,
  parameter int FIRST     = 0
) (
  input  logic [8*BUF_BYTES-1:0] buf_i,
  input  logic [OFF_W-1:0]       cur_i,
  input  logic                   mode_i,
  input  logic                   ok_i,
  output logic [OFF_W-1:0]       start_o,
  output logic                   mode_o,
  output logic [3:0]             len_o,
  output logic [OFF_W-1:0]       end_o,
  output logic                   skip_o,
  output logic                   ok_o
);

  localparam bit IS_FIRST = (FIRST != 0);

  function automatic logic [7:0] byte_at(input logic [OFF_W-1:0] idx);
    logic [7:0] r;
    r = '0;
    for (int i = 0; i < BUF_BYTES; i++)
      if (int'(idx) == i) r = buf_i[8*i +: 8];
    return r;
  endfunction

  logic cur_in_buf;
  logic lead_skip;
  logic tok_hit;
  logic toggle;

  assign cur_in_buf = int'(cur_i) < BUF_BYTES;
  assign lead_skip  = IS_FIRST && mode_i;
  assign tok_hit    = !lead_skip && cur_in_buf && is_switch(byte_at(cur_i));
  assign toggle     = tok_hit;
  assign skip_o     = lead_skip || tok_hit;

  assign start_o = cur_i + OFF_W'(skip_o);
  assign mode_o  = mode_i ^ toggle;
  assign len_o   = insn_len(mode_o, byte_at(start_o));
  assign end_o   = start_o + OFF_W'(len_o);
  assign ok_o    = ok_i && cur_in_buf && (int'(end_o) <= BUF_BYTES);

endmodule

// File: rtl/isx_slot_mux.sv
module isx_slot_mux
  import isx_pkg::*;
#(
  parameter int                BUF_BYTES  = 32,
  parameter int                OFF_W      = 7,
  parameter int                SLOT_BYTES = 8,
  parameter logic [MASK_W-1:0] REACH      = '1
) (
  input  logic [8*BUF_BYTES-1:0]  buf_i,
  input  logic [OFF_W-1:0]        start_i,
  input  logic [3:0]              len_i,
  input  logic                    ok_i,
  output logic [8*SLOT_BYTES-1:0] word_o
);

  localparam int WORD_W = 8 * SLOT_BYTES;

  logic [WORD_W-1:0] cand [BUF_BYTES];

  // One candidate per reachable start; unreachable offsets get no input.
  for (genvar o = 0; o < BUF_BYTES; o++) begin : g_off
    if (REACH[o]) begin : g_live
      logic hit;
      assign hit = int'(start_i) == o;
      for (genvar j = 0; j < SLOT_BYTES; j++) begin : g_lane
        if (o + j < BUF_BYTES) begin : g_in
          assign cand[o][8*j +: 8] = hit ? buf_i[8*(o+j) +: 8] : 8'h00;
        end else begin : g_out
          assign cand[o][8*j +: 8] = 8'h00;
        end
      end
    end else begin : g_dead
      assign cand[o] = '0;
    end
  end

  logic [WORD_W-1:0] sel;

  always_comb begin
    sel = '0;
    for (int o = 0; o < BUF_BYTES; o++) sel = sel | cand[o];
    word_o = sel;
    for (int j = 0; j < SLOT_BYTES; j++)
      if (!ok_i || j >= int'(len_i)) word_o[8*j +: 8] = 8'h00;
  end

endmodule

// File: rtl/isx_extract.sv
module isx_extract
  import isx_pkg::*;
#(
  parameter int BUF_BYTES  = 32,
  parameter int NUM_SLOTS  = 4,
  parameter int SLOT_BYTES = 8,
  parameter bit OUT_REG    = 1'b0,
  localparam int BUF_W     = 8 * BUF_BYTES,
  localparam int WORD_W    = 8 * SLOT_BYTES,
  localparam int OFF_W     = $clog2(BUF_BYTES + NUM_SLOTS * (MAX_LEN + 1) + 1),
  localparam int CNT_W     = $clog2(BUF_BYTES + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [BUF_W-1:0]            fetch_buf,
  input  logic                        start_cmp,
  output logic [NUM_SLOTS*WORD_W-1:0] slot_word,
  output logic [NUM_SLOTS-1:0]        slot_vld,
  output logic [NUM_SLOTS-1:0]        slot_cmp,
  output logic [CNT_W-1:0]            used_bytes
);

  logic [OFF_W-1:0] cur     [NUM_SLOTS+1];
  logic             mode_ch [NUM_SLOTS+1];
  logic             ok_ch   [NUM_SLOTS+1];
  logic [3:0]       len_s   [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] skip_s;

  // Named internal events for the checker.
  logic [NUM_SLOTS*OFF_W-1:0]  st_flat;
  logic [NUM_SLOTS*WORD_W-1:0] c_word;
  logic [NUM_SLOTS-1:0]        c_vld;
  logic [NUM_SLOTS-1:0]        c_cmp;
  logic [CNT_W-1:0]            c_used;

  assign cur[0]     = '0;
  assign mode_ch[0] = start_cmp;
  assign ok_ch[0]   = 1'b1;

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    localparam logic [MASK_W-1:0] RM = reach_mask(k);
    logic [OFF_W-1:0] st;

    isx_step #(
      .BUF_BYTES (BUF_BYTES),
      .OFF_W     (OFF_W),
      .FIRST     (k == 0 ? 1 : 0)
    ) step_i (
      .buf_i   (fetch_buf),
      .cur_i   (cur[k]),
      .mode_i  (mode_ch[k]),
      .ok_i    (ok_ch[k]),
      .start_o (st),
      .mode_o  (mode_ch[k+1]),
      .len_o   (len_s[k]),
      .end_o   (cur[k+1]),
      .skip_o  (skip_s[k]),
      .ok_o    (ok_ch[k+1])
    );

    isx_slot_mux #(
      .BUF_BYTES  (BUF_BYTES),
      .OFF_W      (OFF_W),
      .SLOT_BYTES (SLOT_BYTES),
      .REACH      (RM)
    ) mux_i (
      .buf_i   (fetch_buf),
      .start_i (st),
      .len_i   (len_s[k]),
      .ok_i    (ok_ch[k+1]),
      .word_o  (c_word[k*WORD_W +: WORD_W])
    );

    assign st_flat[k*OFF_W +: OFF_W] = st;
    assign c_vld[k] = ok_ch[k+1];
    assign c_cmp[k] = ok_ch[k+1] && mode_ch[k+1];
  end

  always_comb begin
    c_used = '0;
    for (int k = 0; k < NUM_SLOTS; k++)
      if (ok_ch[k+1]) c_used = CNT_W'(cur[k+1]);
  end

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_word  <= '0;
        slot_vld   <= '0;
        slot_cmp   <= '0;
        used_bytes <= '0;
      end else begin
        slot_word  <= c_word;
        slot_vld   <= c_vld;
        slot_cmp   <= c_cmp;
        used_bytes <= c_used;
      end
    end
  end else begin : g_comb
    assign slot_word  = c_word;
    assign slot_vld   = c_vld;
    assign slot_cmp   = c_cmp;
    assign used_bytes = c_used;
  end

endmodule

// File: rtl/isx_chk.sv
module isx_chk
  import isx_pkg::*;
#(
  parameter int BUF_BYTES  = 32,
  parameter int NUM_SLOTS  = 4,
  parameter int SLOT_BYTES = 8,
  parameter int OFF_W      = 7,
  parameter int CNT_W      = 6
) (
  input logic                               clk,
  input logic                               rst_n,
  input logic [NUM_SLOTS*8*SLOT_BYTES-1:0]  slot_word,
  input logic [NUM_SLOTS-1:0]               slot_vld,
  input logic [NUM_SLOTS-1:0]               slot_cmp,
  input logic [CNT_W-1:0]                   used_bytes,
  input logic [NUM_SLOTS*OFF_W-1:0]         st_flat,
  input logic [NUM_SLOTS-1:0]               int_vld,
  input logic [NUM_SLOTS-1:0]               int_cmp
);

  localparam int WORD_W = 8 * SLOT_BYTES;

  // R8
  vld_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((slot_vld + NUM_SLOTS'(1)) & slot_vld) == '0);

  // R8
  used_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_vld == '0) == (used_bytes == '0));

  // R7
  used_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(used_bytes) <= BUF_BYTES);

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_k
    localparam logic [MASK_W-1:0] RM = reach_mask(k);
    logic [OFF_W-1:0] st;
    assign st = st_flat[k*OFF_W +: OFF_W];

    // R7
    dead_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_vld[k] |-> (slot_word[k*WORD_W +: WORD_W] == '0 && !slot_cmp[k]));

    // R6
    cmp_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      slot_cmp[k] |-> (slot_word[k*WORD_W+16 +: WORD_W-16] == '0));

    // R9
    parity_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int_vld[k] |-> (int_cmp[k] == st[0]));

    // R10
    reach_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int_vld[k] |-> RM[st]);
  end

endmodule

bind isx_extract isx_chk #(
  .BUF_BYTES  (BUF_BYTES),
  .NUM_SLOTS  (NUM_SLOTS),
  .SLOT_BYTES (SLOT_BYTES),
  .OFF_W      (OFF_W),
  .CNT_W      (CNT_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .slot_word  (slot_word),
  .slot_vld   (slot_vld),
  .slot_cmp   (slot_cmp),
  .used_bytes (used_bytes),
  .st_flat    (st_flat),
  .int_vld    (c_vld),
  .int_cmp    (c_cmp)
);

// File: tb/isx_extract_tb_top.sv
module isx_extract_tb_top;

  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [255:0] fbuf = '0;
  logic         smode = 1'b0;

  logic [255:0] w_c, w_r;
  logic [3:0]   v_c, v_r, c_c, c_r;
  logic [5:0]   u_c, u_r;
  logic [255:0] w_s;
  logic [3:0]   v_s, c_s;
  logic [4:0]   u_s;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  isx_extract dut_i (
    .clk(clk), .rst_n(rst_n), .fetch_buf(fbuf), .start_cmp(smode),
    .slot_word(w_c), .slot_vld(v_c), .slot_cmp(c_c), .used_bytes(u_c));

  isx_extract #(.OUT_REG(1'b1)) dut_reg_i (
    .clk(clk), .rst_n(rst_n), .fetch_buf(fbuf), .start_cmp(smode),
    .slot_word(w_r), .slot_vld(v_r), .slot_cmp(c_r), .used_bytes(u_r));

  isx_extract #(.BUF_BYTES(16)) dut_small_i (
    .clk(clk), .rst_n(rst_n), .fetch_buf(fbuf[127:0]), .start_cmp(smode),
    .slot_word(w_s), .slot_vld(v_s), .slot_cmp(c_s), .used_bytes(u_s));

  task automatic chk(input string req, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h exp %h", req, what, act, exp);
    end
  endtask

  // Sequential model written from the requirements.
  function automatic void ref_model(input logic [255:0] b, input int nb, input logic m,
                                    output logic [255:0] w, output logic [3:0] v,
                                    output logic [3:0] c, output int used);
    int cur, len;
    bit ok, md;
    logic [7:0] fb;
    w = '0; v = '0; c = '0; used = 0;
    cur = 0; ok = 1; md = m;
    for (int k = 0; k < 4; k++) begin
      if (!ok || cur >= nb) ok = 0;
      else begin
        if (k == 0 && md) cur++;
        else if (b[8*cur +: 8] == 8'hFB) begin cur++; md = !md; end
        fb = (cur < nb) ? b[8*cur +: 8] : 8'h00;
        len = md ? 2 : ((fb[7:2] == 6'h05) ? 8 : 4);
        if (cur + len > nb) ok = 0;
        else begin
          v[k] = 1'b1;
          c[k] = md;
          for (int i = 0; i < len; i++) w[k*64 + 8*i +: 8] = b[8*(cur+i) +: 8];
          cur += len;
          used = cur;
        end
      end
    end
  endfunction

  task automatic run_case(input string req, input logic [255:0] b, input logic m);
    logic [255:0] ew, sw;
    logic [3:0] ev, ec, sv, sc;
    int eu, su;
    fbuf = b;
    smode = m;
    ref_model(b, 32, m, ew, ev, ec, eu);
    ref_model(b, 16, m, sw, sv, sc, su);
    #1;
    chk(req, "word", w_c, ew);
    chk(req, "vld", 256'(v_c), 256'(ev));
    chk(req, "cmp", 256'(c_c), 256'(ec));
    chk(req, "used", 256'(u_c), 256'(eu));
    chk({req, " R7 small"}, "word", w_s, sw);
    chk({req, " R7 small"}, "vld", 256'(v_s), 256'(sv));
    chk({req, " R8 small"}, "used", 256'(u_s), 256'(su));
    @(posedge clk);
    #1;
    chk("R11 reg", "word", w_r, ew);
    chk("R11 reg", "vld", 256'(v_r), 256'(ev));
    chk("R11 reg", "cmp", 256'(c_r), 256'(ec));
    chk("R11 reg", "used", 256'(u_r), 256'(eu));
  endtask

  task automatic t_reset();
    fbuf = {32{8'h10}};
    #1;
    chk("R11 reset", "word", w_r, '0);
    chk("R11 reset", "vld", 256'(v_r), '0);
    chk("R11 reset", "used", 256'(u_r), '0);
  endtask

  task automatic t_std_short();
    run_case("R1 R4", {32{8'h10}}, 1'b0);
    chk("R1", "vld", 256'(v_c), 256'(4'hF));
    chk("R4", "used", 256'(u_c), 256'(16));
    chk("R6", "slot1", 256'(w_c[127:64]), 256'(64'h10101010));
    chk("R9", "cmp", 256'(c_c), '0);
  endtask

  task automatic t_std_long();
    run_case("R3 R10", {32{8'h14}}, 1'b0);
    chk("R10", "used", 256'(u_c), 256'(32));
    chk("R10", "slot3", 256'(w_c[255:192]), 256'(64'h1414141414141414));
    chk("R7", "small vld", 256'(v_s), 256'(4'h3));
    chk("R8", "small used", 256'(u_s), 256'(16));
  endtask

  task automatic t_compressed();
    logic [255:0] b;
    b = {32{8'h20}};
    b[7:0] = 8'h77;
    b[15:8] = 8'h31;
    run_case("R2", b, 1'b1);
    chk("R2", "slot0", 256'(w_c[63:0]), 256'(64'h2031));
    chk("R9", "cmp", 256'(c_c), 256'(4'hF));
    chk("R3", "used", 256'(u_c), 256'(9));
  endtask

  task automatic t_switch();
    logic [255:0] b;
    b = {32{8'h10}};
    b[8*4 +: 8] = 8'hFB;
    b[8*5 +: 8] = 8'h42;
    b[8*7 +: 8] = 8'hFB;
    run_case("R5", b, 1'b0);
    chk("R5", "cmp", 256'(c_c), 256'(4'b0010));
    chk("R5", "slot1", 256'(w_c[127:64]), 256'(64'h1042));
    chk("R5", "slot2", 256'(w_c[191:128]), 256'(64'h10101010));
    chk("R4", "used", 256'(u_c), 256'(16));
    b = {32{8'h10}};
    b[7:0] = 8'hFB;
    b[15:8] = 8'hFB;
    b[23:16] = 8'h33;
    run_case("R5 R1", b, 1'b0);
    chk("R5", "double", 256'(w_c[63:0]), 256'(64'h33FB));
    chk("R1", "cmp0", 256'(c_c[0]), 256'(1));
    b = {32{8'h10}};
    b[7:0] = 8'hFB;
    run_case("R2", b, 1'b1);
    chk("R2", "no toggle", 256'(c_c[0]), 256'(1));
  endtask

  task automatic t_random();
    logic [255:0] b;
    for (int it = 0; it < 300; it++) begin
      for (int i = 0; i < 32; i++) begin
        case ($urandom_range(0, 3))
          0: b[8*i +: 8] = 8'h10;
          1: b[8*i +: 8] = 8'h14;
          2: b[8*i +: 8] = 8'hFB;
          default: b[8*i +: 8] = 8'($urandom);
        endcase
      end
      run_case("R4 R5 R6 R7 R8 rand", b, 1'($urandom_range(0, 1)));
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    t_std_short();
    t_std_long();
    t_compressed();
    t_switch();
    t_random();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule